// File: doc/BRIEF.md
# Trimmed-Mean Acquisition and Error Generator

This block sits between a sampled sensor stream and a feedback controller. It gathers 8-bit samples into a small local buffer in groups of ten. Once a group is complete, it scans the buffer once. During that scan it keeps a running sum and records the largest and smallest sample. It then removes one largest and one smallest sample and divides the remaining eight by eight, rounding down. This gives a filtered reading that is protected against single-sample spikes in either direction.

The filtered reading is subtracted from a setpoint to give the control error. The previous error is held in a register, so the block can also report how much the error changed from one group to the next. Both values appear together with a one-cycle valid pulse. A controller downstream uses that pulse as its sampling strobe.

Top module: `trimmed_err_gen`

## Requirements
- R1: While reset is high and on the cycle after it, err_valid is 0, and err and err_rate are both 0.
- R2: Every ten accepted samples form one group. A group holds exactly the samples accepted since the previous group ended, and nothing else.
- R3: The filtered value equals (sum of the ten samples − largest − smallest) shifted right by 3, rounding down, and lies in the range 0..255.
- R4: When several samples share the largest or the smallest value, only one instance of each is removed.
- R5: err = setpoint − filtered value, as a 9-bit two's complement number. The setpoint is read on the clock edge that raises err_valid.
- R6: err_rate = err − previous err, as a 10-bit two's complement number. For the first group after reset, err_rate is 0.
- R7: err_valid is a one-cycle pulse. It rises on the 11th rising edge after the edge that accepts the tenth sample of a group. err and err_rate hold their values between pulses.
- R8: A sample presented from the edge after the tenth acceptance up to and including the edge that raises err_valid is ignored. The next group starts with the first sample after that window.
- R9: A synchronous reset in the middle of a group discards the partial group and the stored previous error.
- R10: Samples may arrive with any number of idle cycles between them without changing the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | sample_data is present this cycle |
| sample_data | input | 8 | Unsigned sensor sample |
| setpoint | input | 8 | Unsigned target value |
| err | output | 9 | Signed error, setpoint minus filtered value |
| err_rate | output | 10 | Signed change of err since the previous group |
| err_valid | output | 1 | One-cycle strobe marking new err and err_rate |

## Verification
A write or scan address that drifts by one either moves the group boundary or pulls a stale buffer entry into the scan. Either fault shows up as a wrong err on the very next pulse, or as a pulse that comes too early or too late. A running maximum or minimum that is seeded wrongly, or that drops duplicates, changes the filtered value, and therefore err, in the same group. A stale or missing previous-error register shows up in err_rate on the first pulse after reset, or on the pulse that follows it.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_SCAN    = 2'd1,
        PH_EMIT    = 2'd2
    } phase_e;
endpackage

// File: rtl/tm_addr_ctrl.sv
module tm_addr_ctrl #(
    parameter int GROUP_N = 10,
    parameter int ADDR_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                scan_en,
    output logic                scan_first,
    output logic                emit,
    output tm_pkg::phase_e      phase
);
    import tm_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(GROUP_N - 1);

    typedef struct packed {
        phase_e             ph;
        logic [ADDR_W-1:0]  wa;
        logic [ADDR_W-1:0]  ra;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        wr_en      = (st_q.ph == PH_COLLECT) && sample_valid;
        scan_en    = (st_q.ph == PH_SCAN);
        scan_first = scan_en && (st_q.ra == '0);
        emit       = (st_q.ph == PH_EMIT);
        case (st_q.ph)
            PH_COLLECT: begin
                if (sample_valid) begin
                    if (st_q.wa == LAST) begin
                        st_d.wa = '0;
                        st_d.ra = '0;
                        st_d.ph = PH_SCAN;
                    end else begin
                        st_d.wa = st_q.wa + 1'b1;
                    end
                end
            end
            PH_SCAN: begin
                if (st_q.ra == LAST) begin
                    st_d.ra = '0;
                    st_d.ph = PH_EMIT;
                end else begin
                    st_d.ra = st_q.ra + 1'b1;
                end
            end
            PH_EMIT:  st_d.ph = PH_COLLECT;
            default:  st_d.ph = PH_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph <= PH_COLLECT;
            st_q.wa <= '0;
            st_q.ra <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.wa;
    assign rd_addr = st_q.ra;
    assign phase   = st_q.ph;
endmodule

// File: rtl/tm_sample_mem.sv
module tm_sample_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 10,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && (waddr == ADDR_W'(g))) begin
                cell_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == ADDR_W'(i)) begin
                rdata = cell_q[i];
            end
        end
    end
endmodule

// File: rtl/tm_minmax_acc.sv
module tm_minmax_acc #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              scan_first,
    input  logic [DATA_W-1:0] din,
    output logic [SUM_W-1:0]  sum,
    output logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] lo
);
    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [SUM_W-1:0] din_ext;

    always_comb begin
        din_ext = {{(SUM_W-DATA_W){1'b0}}, din};
        acc_d   = acc_q;
        if (scan_en) begin
            if (scan_first) begin
                acc_d.sum = din_ext;
                acc_d.hi  = din;
                acc_d.lo  = din;
            end else begin
                acc_d.sum = acc_q.sum + din_ext;
                acc_d.hi  = (din > acc_q.hi) ? din : acc_q.hi;
                acc_d.lo  = (din < acc_q.lo) ? din : acc_q.lo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sum = acc_q.sum;
    assign hi  = acc_q.hi;
    assign lo  = acc_q.lo;
endmodule

// File: rtl/tm_err_stage.sv
module tm_err_stage #(
    parameter int DATA_W     = 8,
    parameter int SUM_W      = 12,
    parameter int KEEP_SHIFT = 3,
    parameter int ERR_W      = 9,
    parameter int RATE_W     = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     emit,
    input  logic [SUM_W-1:0]         sum,
    input  logic [DATA_W-1:0]        hi,
    input  logic [DATA_W-1:0]        lo,
    input  logic [DATA_W-1:0]        setpoint,
    output logic signed [ERR_W-1:0]  err,
    output logic signed [RATE_W-1:0] err_rate,
    output logic                     err_valid
);
    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [RATE_W-1:0] rate;
        logic              valid;
        logic              have_prev;
    } out_t;

    out_t o_d, o_q;

    logic [SUM_W-1:0]         trimmed;
    logic [DATA_W-1:0]        avg;
    logic signed [ERR_W-1:0]  e_new;
    logic signed [RATE_W-1:0] r_new;

    always_comb begin
        trimmed = sum - {{(SUM_W-DATA_W){1'b0}}, hi} - {{(SUM_W-DATA_W){1'b0}}, lo};
        avg     = DATA_W'(trimmed >> KEEP_SHIFT);
        e_new   = $signed({1'b0, setpoint}) - $signed({1'b0, avg});
        r_new   = $signed({e_new[ERR_W-1], e_new}) - $signed({o_q.err[ERR_W-1], o_q.err});
        o_d       = o_q;
        o_d.valid = emit;
        if (emit) begin
            o_d.err       = e_new;
            o_d.rate      = o_q.have_prev ? r_new : '0;
            o_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign err       = o_q.err;
    assign err_rate  = o_q.rate;
    assign err_valid = o_q.valid;
endmodule

// File: rtl/trimmed_err_gen.sv
module trimmed_err_gen #(
    parameter int DATA_W  = 8,
    parameter int GROUP_N = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic [DATA_W-1:0]       sample_data,
    input  logic [DATA_W-1:0]       setpoint,
    output logic signed [DATA_W:0]  err,
    output logic signed [DATA_W+1:0] err_rate,
    output logic                    err_valid
);
    localparam int ADDR_W     = $clog2(GROUP_N);
    localparam int SUM_W      = DATA_W + $clog2(GROUP_N);
    localparam int KEEP_SHIFT = $clog2(GROUP_N - 2);
    localparam int ERR_W      = DATA_W + 1;
    localparam int RATE_W     = DATA_W + 2;

    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;
    logic [ADDR_W-1:0]    rd_addr;
    logic                 scan_en;
    logic                 scan_first;
    logic                 emit;
    tm_pkg::phase_e       phase;
    logic [DATA_W-1:0]    rd_data;
    logic [SUM_W-1:0]     acc_sum;
    logic [DATA_W-1:0]    acc_hi;
    logic [DATA_W-1:0]    acc_lo;

    tm_addr_ctrl #(.GROUP_N(GROUP_N), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .scan_en(scan_en), .scan_first(scan_first), .emit(emit), .phase(phase)
    );

    tm_sample_mem #(.DATA_W(DATA_W), .DEPTH(GROUP_N), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(sample_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    tm_minmax_acc #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_acc (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_first(scan_first),
        .din(rd_data), .sum(acc_sum), .hi(acc_hi), .lo(acc_lo)
    );

    tm_err_stage #(
        .DATA_W(DATA_W), .SUM_W(SUM_W), .KEEP_SHIFT(KEEP_SHIFT),
        .ERR_W(ERR_W), .RATE_W(RATE_W)
    ) u_err (
        .clk(clk), .rst(rst), .emit(emit), .sum(acc_sum), .hi(acc_hi), .lo(acc_lo),
        .setpoint(setpoint), .err(err), .err_rate(err_rate), .err_valid(err_valid)
    );
endmodule

// File: rtl/tm_err_chk.sv
module tm_err_chk #(
    parameter int DATA_W  = 8,
    parameter int GROUP_N = 10,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  tm_pkg::phase_e           phase,
    input  logic                     err_valid,
    input  logic signed [DATA_W:0]   err,
    input  logic signed [DATA_W+1:0] err_rate
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(GROUP_N - 1);
    localparam int LAT_W = $clog2(GROUP_N + 4) + 1;

    logic [LAT_W-1:0]       lat_cnt;
    logic                   lat_armed;
    logic                   seen_valid;
    logic signed [DATA_W:0] prev_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt    <= '0;
            lat_armed  <= 1'b0;
            seen_valid <= 1'b0;
            prev_err   <= '0;
        end else begin
            if (wr_en && (wr_addr == LAST)) begin
                lat_armed <= 1'b1;
                lat_cnt   <= LAT_W'(1);
            end else if (lat_armed) begin
                lat_cnt <= lat_cnt + 1'b1;
                if (err_valid) lat_armed <= 1'b0;
            end
            if (err_valid) begin
                seen_valid <= 1'b1;
                prev_err   <= err;
            end
        end
    end

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (lat_armed && (lat_cnt == LAT_W'(GROUP_N + 2))));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !err_valid |-> ($stable(err) && $stable(err_rate)));

    // R6
    first_rate_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid && !seen_valid) |-> (err_rate == '0));

    // R6
    rate_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid && seen_valid) |->
        (err_rate == ($signed({err[DATA_W], err}) - $signed({prev_err[DATA_W], prev_err}))));

    // R8
    no_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != tm_pkg::PH_COLLECT) |-> !wr_en);
endmodule

bind trimmed_err_gen tm_err_chk #(
    .DATA_W(DATA_W), .GROUP_N(GROUP_N), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .phase(phase),
    .err_valid(err_valid), .err(err), .err_rate(err_rate)
);

// File: tb/tb_trimmed_err_gen.sv
module tb_trimmed_err_gen;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_valid = 1'b0;
    logic [7:0]        sample_data = '0;
    logic [7:0]        setpoint = '0;
    logic signed [8:0] err;
    logic signed [9:0] err_rate;
    logic              err_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int prev_e   = 0;
    bit have_prev = 1'b0;

    always #4 clk = ~clk;

    trimmed_err_gen dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_data(sample_data),
        .setpoint(setpoint), .err(err), .err_rate(err_rate), .err_valid(err_valid)
    );

    localparam int NV = 6;
    localparam logic [79:0] VEC_S [NV] = '{
        {8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100},
        {8'd100, 8'd90,  8'd80,  8'd70,  8'd60,  8'd50,  8'd40,  8'd30,  8'd20,  8'd10},
        {8'd5,   8'd4,   8'd3,   8'd2,   8'd1,   8'd0,   8'd0,   8'd255, 8'd255, 8'd255},
        {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
        {8'd3,   8'd3,   8'd3,   8'd3,   8'd3,   8'd250, 8'd1,   8'd9,   8'd8,   8'd7}
    };
    localparam logic [7:0] VEC_SP [NV] = '{8'd100, 8'd50, 8'd200, 8'd0, 8'd255, 8'd10};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int trim_avg(input logic [79:0] v);
        int s = 0;
        int mx = 0;
        int mn = 255;
        for (int i = 0; i < 10; i++) begin
            int x = int'(v[8*i +: 8]);
            s += x;
            if (x > mx) mx = x;
            if (x < mn) mn = x;
        end
        return (s - mx - mn) / 8;
    endfunction

    task automatic run_group(input logic [79:0] v, input logic [7:0] sp,
                             input int gap, input bit flood, input string req);
        int exp_e;
        int exp_r;
        bit early = 1'b0;
        setpoint = sp;
        for (int i = 0; i < 10; i++) begin
            if (i > 0) repeat (gap) @(negedge clk);
            @(negedge clk);
            sample_valid = 1'b1;
            sample_data  = v[8*i +: 8];
            if (gap > 0 || i == 9) begin
                @(negedge clk);
                sample_valid = 1'b0;
            end
        end
        if (gap > 0) begin
            // already at negedge after the accepting edge
        end
        for (int k = 1; k <= 11; k++) begin
            sample_valid = flood;
            sample_data  = 8'hFF;
            @(negedge clk);
            if (k < 11 && err_valid) early = 1'b1;
        end
        sample_valid = 1'b0;
        exp_e = int'(sp) - trim_avg(v);
        exp_r = have_prev ? (exp_e - prev_e) : 0;
        check(err_valid && !early, {"R7 pulse timing ", req}, int'(err_valid), 1);
        check(int'(err) == exp_e, {"R3/R5 err ", req}, int'(err), exp_e);
        check(int'(err_rate) == exp_r, {"R6 err_rate ", req}, int'(err_rate), exp_r);
        prev_e    = exp_e;
        have_prev = 1'b1;
        @(negedge clk);
        check(!err_valid, {"R7 single-cycle pulse ", req}, int'(err_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!err_valid && err == 0 && err_rate == 0, "R1 during reset", int'(err), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!err_valid && err == 0 && err_rate == 0, "R1 after reset", int'(err_valid), 0);

        // R2 R3 R4 R5 R6 table walk
        for (int n = 0; n < NV; n++) begin
            run_group(VEC_S[n], VEC_SP[n], 0, 1'b0, $sformatf("R2 vec%0d", n));
        end

        // R7 hold between pulses
        repeat (6) @(negedge clk);
        check(int'(err) == prev_e, "R7 err held", int'(err), prev_e);

        // R10 idle gaps between samples
        run_group(VEC_S[1], 8'd77, 3, 1'b0, "R10 gap3");

        // R8 flood during processing, then a clean group must be unaffected
        run_group(VEC_S[2], 8'd128, 0, 1'b1, "R8 flooded");
        run_group(VEC_S[5], 8'd40, 0, 1'b0, "R8 next group");

        // R9 reset mid-group
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sample_valid = 1'b1;
            sample_data  = 8'd250;
        end
        @(negedge clk);
        sample_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        have_prev = 1'b0;
        check(err == 0 && err_rate == 0, "R9 outputs cleared", int'(err), 0);
        run_group(VEC_S[1], 8'd60, 0, 1'b0, "R9 after reset");
        run_group(VEC_S[0], 8'd90, 1, 1'b0, "R9 second");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule